// File: doc/BRIEF.md
# Circle Command Fetch Controller

This controller feeds a bank of circle-drawing engines with no help from the processor once a job has started. The processor writes the byte address of a table of circle records to the start register. The controller then walks that table through its own read port on program memory. For each record it gathers centre x, centre y and radius, packs them into one engine command, and hands the command to a free engine. The processor polls the status register until it reads zero. At that point every record has been dispatched and every engine has gone idle.

The processor-facing registers run on the processor clock. The fetch sequencer, the dispatcher and the engine interface run on a separate, faster core clock. A start request crosses into the core domain as a toggle, and the core returns an acknowledge toggle. The core busy flag comes back through a two-flop synchronizer.

The core sequencer is a state machine with seven states:
- `S_IDLE`: waits for a start request.
- `S_RD_X`: reads word 0 of a record.
- `S_RD_Y`: reads word 1 and captures x.
- `S_RD_R`: reads word 2 and captures y.
- `S_WAIT_R`: captures the radius.
- `S_DISPATCH`: waits for a ready engine.
- `S_DRAIN`: waits until no engine is busy.

The transitions are:
- start: `S_IDLE` to `S_RD_X`.
- read chain: `S_RD_X` to `S_RD_Y` to `S_RD_R` to `S_WAIT_R` to `S_DISPATCH`.
- next record: `S_DISPATCH` to `S_RD_X`, on a dispatch that is not the last.
- last record: `S_DISPATCH` to `S_DRAIN`, on the final dispatch.
- stall: `S_DISPATCH` stays in `S_DISPATCH` while no engine is ready.
- finish: `S_DRAIN` to `S_IDLE` once all engine busy inputs are low.

Top module: `circle_fetch_ctrl`

## Requirements
- R1: After reset the status register (offset 4) reads 0, `mem_rd_en` is low and `eng_valid` is all zero.
- R2: A processor write to offset 0 while idle starts a job whose table begins at byte address `cpu_wdata[ADDR_W-1:0]`; a read of offset 4 returns 1 from the next processor cycle on.
- R3: Record i is read as three single-cycle reads at byte addresses base+12i, base+12i+4 and base+12i+8, in that order, for i = 0 .. NUM_CIRCLES-1 ascending. The three words hold centre x, centre y and radius, and the read data is used one core cycle after each read.
- R4: Exactly one command is dispatched per record, in record order. Command bits [8:0] are x[8:0], bits [17:9] are y[8:0] and bits [25:18] are radius[7:0].
- R5: At most one `eng_valid` bit is high in any cycle, and only for an engine whose `eng_ready` is high; the engine takes the command on that clock edge.
- R6: The dispatcher picks the first engine with `eng_ready` high, searching in ascending index order with wrap-around and starting just after the engine last served. Right after reset the search starts at engine 0.
- R7: While no engine is ready, the loaded command is held, nothing is dispatched and no further memory reads are issued.
- R8: Offset 4 keeps reading 1 after the last dispatch until every `eng_busy` bit is low. It reads 0 within a few processor cycles after that. An engine must raise `eng_busy` by the core edge that follows acceptance.
- R9: A write to offset 0 while offset 4 reads 1 is ignored: the running job is unchanged and no further job follows it.
- R10: The core busy flag reaches the processor domain through a two-flop synchronizer; offset 4 reads 1 while a start request is unacknowledged or the synchronized flag is high.
- R11: Writes to any offset other than 0 start nothing, and reads of any offset other than 4 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cpu_clk | input | 1 | Processor interface clock |
| cpu_rst_n | input | 1 | Active-low reset, processor domain |
| cpu_wr_en | input | 1 | Register write strobe |
| cpu_addr | input | REG_AW | Register byte offset |
| cpu_wdata | input | 32 | Register write data |
| cpu_rdata | output | 32 | Register read data (combinational from cpu_addr) |
| core_clk | input | 1 | Fetch and engine clock |
| core_rst_n | input | 1 | Active-low reset, core domain |
| mem_rd_en | output | 1 | Program memory read strobe |
| mem_addr | output | ADDR_W | Program memory byte address |
| mem_rdata | input | 32 | Read data, valid one core cycle after the strobe |
| eng_valid | output | NUM_ENG | One-hot command strobe per engine |
| eng_cmd | output | 26 | Packed command shared by all engines |
| eng_ready | input | NUM_ENG | Engine can accept a command |
| eng_busy | input | NUM_ENG | Engine is drawing |

## Verification
The status bit is due on the processor cycle after the start write, through the unacknowledged-request path. It clears two to three processor cycles after the core leaves drain.

Memory reads and dispatches are not tied to fixed cycle numbers, because their timing depends on engine readiness. The bench therefore queues the expected addresses and commands when it starts a job. A monitor pops one entry at each read strobe or valid strobe, checking between core edges, and the memory model returns data exactly one core cycle after each strobe.

Stalls and drains are checked over windows: read and dispatch counters must stay frozen while every engine is held not ready. The status bit is polled every processor cycle, and any zero seen while an engine is still busy is a failure.

// File: rtl/cfc_pkg.sv
package cfc_pkg;

    localparam int COORD_W = 9;
    localparam int RAD_W   = 8;
    localparam int CMD_W   = RAD_W + 2 * COORD_W;

    typedef enum logic [2:0] {
        S_IDLE,
        S_RD_X,
        S_RD_Y,
        S_RD_R,
        S_WAIT_R,
        S_DISPATCH,
        S_DRAIN
    } fetch_state_e;

    typedef struct packed {
        logic [RAD_W-1:0]   rad;
        logic [COORD_W-1:0] cy;
        logic [COORD_W-1:0] cx;
    } circ_cmd_t;

endpackage

// File: rtl/cfc_cpu_regs.sv
module cfc_cpu_regs #(
    parameter int ADDR_W = 16,
    parameter int REG_AW = 4,
    parameter int DATA_W = 32
) (
    input  logic              cpu_clk,
    input  logic              cpu_rst_n,
    input  logic              cpu_wr_en,
    input  logic [REG_AW-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    input  logic              core_busy,
    input  logic              core_ack_tgl,
    output logic              req_tgl,
    output logic [ADDR_W-1:0] base_addr
);

    localparam logic [REG_AW-1:0] OFF_START  = REG_AW'(0);
    localparam logic [REG_AW-1:0] OFF_STATUS = REG_AW'(4);

    logic ack_s1, ack_s2;
    logic bsy_s1, bsy_s2;
    logic pending;
    logic busy_rd;
    logic accept;

    assign pending = req_tgl ^ ack_s2;
    assign busy_rd = pending | bsy_s2;
    assign accept  = cpu_wr_en && (cpu_addr == OFF_START) && !busy_rd;

    always_ff @(posedge cpu_clk or negedge cpu_rst_n) begin
        if (!cpu_rst_n) begin
            ack_s1    <= 1'b0;
            ack_s2    <= 1'b0;
            bsy_s1    <= 1'b0;
            bsy_s2    <= 1'b0;
            req_tgl   <= 1'b0;
            base_addr <= '0;
        end else begin
            ack_s1 <= core_ack_tgl;
            ack_s2 <= ack_s1;
            bsy_s1 <= core_busy;
            bsy_s2 <= bsy_s1;
            if (accept) begin
                req_tgl   <= ~req_tgl;
                base_addr <= cpu_wdata[ADDR_W-1:0];
            end
        end
    end

    always_comb begin
        cpu_rdata = '0;
        if (cpu_addr == OFF_STATUS) begin
            cpu_rdata[0] = busy_rd;
        end
    end

    // R2: an accepted start shows as busy on the next cycle
    p_start_busy_r2: assert property (@(posedge cpu_clk) disable iff (!cpu_rst_n)
        accept |=> busy_rd);

    // R9: a start write while busy leaves the request toggle and base alone
    p_ignore_busy_r9: assert property (@(posedge cpu_clk) disable iff (!cpu_rst_n)
        (cpu_wr_en && cpu_addr == OFF_START && busy_rd) |=> ($stable(req_tgl) && $stable(base_addr)));

endmodule

// File: rtl/cfc_rr_dispatch.sv
module cfc_rr_dispatch #(
    parameter int NUM_ENG = 4
) (
    input  logic               core_clk,
    input  logic               core_rst_n,
    input  logic               disp_req,
    input  logic [NUM_ENG-1:0] eng_ready,
    output logic [NUM_ENG-1:0] eng_grant,
    output logic               disp_fire
);

    localparam int ENG_W = (NUM_ENG > 1) ? $clog2(NUM_ENG) : 1;

    logic [ENG_W-1:0] last_q;
    logic [ENG_W-1:0] sel_idx;
    logic             found;
    int               cand;

    always_comb begin
        found   = 1'b0;
        sel_idx = '0;
        cand    = 0;
        for (int off = 1; off <= NUM_ENG; off++) begin
            cand = int'(last_q) + off;
            if (cand >= NUM_ENG) begin
                cand = cand - NUM_ENG;
            end
            if (!found && eng_ready[cand]) begin
                found   = 1'b1;
                sel_idx = cand[ENG_W-1:0];
            end
        end
    end

    assign disp_fire = disp_req && found;

    always_comb begin
        eng_grant = '0;
        if (disp_fire) begin
            eng_grant[sel_idx] = 1'b1;
        end
    end

    always_ff @(posedge core_clk or negedge core_rst_n) begin
        if (!core_rst_n) begin
            last_q <= ENG_W'(NUM_ENG - 1);
        end else if (disp_fire) begin
            last_q <= sel_idx;
        end
    end

    // R5: never more than one engine strobed
    p_onehot_r5: assert property (@(posedge core_clk) disable iff (!core_rst_n)
        $onehot0(eng_grant));

    // R5: a strobed engine must be ready
    p_grant_ready_r5: assert property (@(posedge core_clk) disable iff (!core_rst_n)
        ((eng_grant & ~eng_ready) == '0));

    // R7: a request with no ready engine strobes nothing
    p_no_ready_r7: assert property (@(posedge core_clk) disable iff (!core_rst_n)
        (disp_req && eng_ready == '0) |-> (eng_grant == '0));

endmodule

// File: rtl/cfc_fetch_seq.sv
module cfc_fetch_seq
    import cfc_pkg::*;
#(
    parameter int NUM_CIRCLES = 50,
    parameter int ADDR_W      = 16,
    parameter int DATA_W      = 32,
    parameter int NUM_ENG     = 4
) (
    input  logic               core_clk,
    input  logic               core_rst_n,
    input  logic               req_tgl,
    input  logic [ADDR_W-1:0]  base_addr,
    output logic               ack_tgl,
    output logic               busy_q,
    output logic               mem_rd_en,
    output logic [ADDR_W-1:0]  mem_addr,
    input  logic [DATA_W-1:0]  mem_rdata,
    output logic               disp_req,
    input  logic               disp_fire,
    output circ_cmd_t          cmd,
    input  logic [NUM_ENG-1:0] eng_busy
);

    localparam int IDX_W      = $clog2(NUM_CIRCLES + 1);
    localparam int WORD_BYTES = DATA_W / 8;
    localparam int REC_BYTES  = 3 * WORD_BYTES;

    fetch_state_e state_q, state_d;

    logic             rq_s1, rq_s2;
    logic             start;
    logic [ADDR_W-1:0] ptr_q;
    logic [IDX_W-1:0]  idx_q;
    logic              last_rec;

    assign start    = (rq_s2 != ack_tgl) && (state_q == S_IDLE);
    assign last_rec = (idx_q == IDX_W'(NUM_CIRCLES - 1));

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:     if (start) state_d = S_RD_X;
            S_RD_X:     state_d = S_RD_Y;
            S_RD_Y:     state_d = S_RD_R;
            S_RD_R:     state_d = S_WAIT_R;
            S_WAIT_R:   state_d = S_DISPATCH;
            S_DISPATCH: if (disp_fire) state_d = last_rec ? S_DRAIN : S_RD_X;
            S_DRAIN:    if (eng_busy == '0) state_d = S_IDLE;
            default:    state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge core_clk or negedge core_rst_n) begin
        if (!core_rst_n) begin
            state_q <= S_IDLE;
            busy_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            busy_q  <= (state_d != S_IDLE);
        end
    end

    // outputs
    always_comb begin
        mem_rd_en = 1'b0;
        mem_addr  = ptr_q;
        disp_req  = 1'b0;
        unique case (state_q)
            S_RD_X: begin
                mem_rd_en = 1'b1;
                mem_addr  = ptr_q;
            end
            S_RD_Y: begin
                mem_rd_en = 1'b1;
                mem_addr  = ptr_q + ADDR_W'(WORD_BYTES);
            end
            S_RD_R: begin
                mem_rd_en = 1'b1;
                mem_addr  = ptr_q + ADDR_W'(2 * WORD_BYTES);
            end
            S_DISPATCH: disp_req = 1'b1;
            default: ;
        endcase
    end

    // datapath and handshake
    always_ff @(posedge core_clk or negedge core_rst_n) begin
        if (!core_rst_n) begin
            rq_s1   <= 1'b0;
            rq_s2   <= 1'b0;
            ack_tgl <= 1'b0;
            ptr_q   <= '0;
            idx_q   <= '0;
            cmd     <= '0;
        end else begin
            rq_s1 <= req_tgl;
            rq_s2 <= rq_s1;
            if (start) begin
                ack_tgl <= rq_s2;
                ptr_q   <= base_addr;
                idx_q   <= '0;
            end
            if (state_q == S_RD_Y)   cmd.cx  <= mem_rdata[COORD_W-1:0];
            if (state_q == S_RD_R)   cmd.cy  <= mem_rdata[COORD_W-1:0];
            if (state_q == S_WAIT_R) cmd.rad <= mem_rdata[RAD_W-1:0];
            if (state_q == S_DISPATCH && disp_fire) begin
                ptr_q <= ptr_q + ADDR_W'(REC_BYTES);
                idx_q <= idx_q + IDX_W'(1);
            end
        end
    end

    // R3: reads within one record step by one word
    p_addr_step_r3: assert property (@(posedge core_clk) disable iff (!core_rst_n)
        (mem_rd_en && $past(mem_rd_en)) |-> (mem_addr == $past(mem_addr) + ADDR_W'(WORD_BYTES)));

    // R7: a stalled dispatch issues no read on the next cycle
    p_stall_hold_r7: assert property (@(posedge core_clk) disable iff (!core_rst_n)
        (state_q == S_DISPATCH && !disp_fire) |=> (!mem_rd_en && $stable(cmd)));

    // R8: draining with a busy engine keeps the job busy
    p_drain_busy_r8: assert property (@(posedge core_clk) disable iff (!core_rst_n)
        (state_q == S_DRAIN && eng_busy != '0) |=> busy_q);

    // R9: nothing moves on the memory or engine side when idle
    p_idle_quiet_r9: assert property (@(posedge core_clk) disable iff (!core_rst_n)
        !busy_q |-> (!mem_rd_en && !disp_req));

endmodule

// File: rtl/circle_fetch_ctrl.sv
module circle_fetch_ctrl
    import cfc_pkg::*;
#(
    parameter int NUM_CIRCLES = 50,
    parameter int NUM_ENG     = 4,
    parameter int ADDR_W      = 16,
    parameter int REG_AW      = 4,
    parameter int DATA_W      = 32
) (
    input  logic               cpu_clk,
    input  logic               cpu_rst_n,
    input  logic               cpu_wr_en,
    input  logic [REG_AW-1:0]  cpu_addr,
    input  logic [DATA_W-1:0]  cpu_wdata,
    output logic [DATA_W-1:0]  cpu_rdata,
    input  logic               core_clk,
    input  logic               core_rst_n,
    output logic               mem_rd_en,
    output logic [ADDR_W-1:0]  mem_addr,
    input  logic [DATA_W-1:0]  mem_rdata,
    output logic [NUM_ENG-1:0] eng_valid,
    output logic [CMD_W-1:0]   eng_cmd,
    input  logic [NUM_ENG-1:0] eng_ready,
    input  logic [NUM_ENG-1:0] eng_busy
);

    logic              req_tgl;
    logic              ack_tgl;
    logic              core_busy;
    logic [ADDR_W-1:0] base_addr;
    logic              disp_req;
    logic              disp_fire;
    circ_cmd_t         cmd;

    cfc_cpu_regs #(
        .ADDR_W (ADDR_W),
        .REG_AW (REG_AW),
        .DATA_W (DATA_W)
    ) u_regs (
        .cpu_clk      (cpu_clk),
        .cpu_rst_n    (cpu_rst_n),
        .cpu_wr_en    (cpu_wr_en),
        .cpu_addr     (cpu_addr),
        .cpu_wdata    (cpu_wdata),
        .cpu_rdata    (cpu_rdata),
        .core_busy    (core_busy),
        .core_ack_tgl (ack_tgl),
        .req_tgl      (req_tgl),
        .base_addr    (base_addr)
    );

    cfc_fetch_seq #(
        .NUM_CIRCLES (NUM_CIRCLES),
        .ADDR_W      (ADDR_W),
        .DATA_W      (DATA_W),
        .NUM_ENG     (NUM_ENG)
    ) u_seq (
        .core_clk   (core_clk),
        .core_rst_n (core_rst_n),
        .req_tgl    (req_tgl),
        .base_addr  (base_addr),
        .ack_tgl    (ack_tgl),
        .busy_q     (core_busy),
        .mem_rd_en  (mem_rd_en),
        .mem_addr   (mem_addr),
        .mem_rdata  (mem_rdata),
        .disp_req   (disp_req),
        .disp_fire  (disp_fire),
        .cmd        (cmd),
        .eng_busy   (eng_busy)
    );

    cfc_rr_dispatch #(
        .NUM_ENG (NUM_ENG)
    ) u_disp (
        .core_clk   (core_clk),
        .core_rst_n (core_rst_n),
        .disp_req   (disp_req),
        .eng_ready  (eng_ready),
        .eng_grant  (eng_valid),
        .disp_fire  (disp_fire)
    );

    assign eng_cmd = cmd;

endmodule

// File: tb/circle_fetch_ctrl_bench.sv
module circle_fetch_ctrl_bench;

    localparam int N      = 50;
    localparam int NE     = 4;
    localparam int AW     = 16;
    localparam int RAW    = 4;
    localparam int DW     = 32;
    localparam int CW     = 26;

    logic          cpu_clk = 1'b0;
    logic          core_clk = 1'b0;
    logic          cpu_rst_n = 1'b0;
    logic          core_rst_n = 1'b0;
    logic          cpu_wr_en = 1'b0;
    logic [RAW-1:0] cpu_addr = '0;
    logic [DW-1:0] cpu_wdata = '0;
    logic [DW-1:0] cpu_rdata;
    logic          mem_rd_en;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_rdata = '0;
    logic [NE-1:0] eng_valid;
    logic [CW-1:0] eng_cmd;
    logic [NE-1:0] eng_ready = '0;
    logic [NE-1:0] eng_busy = '0;

    always #5   cpu_clk  = ~cpu_clk;
    always #2.5 core_clk = ~core_clk;

    circle_fetch_ctrl #(
        .NUM_CIRCLES (N),
        .NUM_ENG     (NE),
        .ADDR_W      (AW),
        .REG_AW      (RAW),
        .DATA_W      (DW)
    ) u_circle_fetch_ctrl (
        .cpu_clk    (cpu_clk),
        .cpu_rst_n  (cpu_rst_n),
        .cpu_wr_en  (cpu_wr_en),
        .cpu_addr   (cpu_addr),
        .cpu_wdata  (cpu_wdata),
        .cpu_rdata  (cpu_rdata),
        .core_clk   (core_clk),
        .core_rst_n (core_rst_n),
        .mem_rd_en  (mem_rd_en),
        .mem_addr   (mem_addr),
        .mem_rdata  (mem_rdata),
        .eng_valid  (eng_valid),
        .eng_cmd    (eng_cmd),
        .eng_ready  (eng_ready),
        .eng_busy   (eng_busy)
    );

    int checks   = 0;
    int failures = 0;
    bit finished = 1'b0;

    logic [AW-1:0] exp_addr[$];
    logic [CW-1:0] exp_cmd[$];
    int            read_cnt  = 0;
    int            valid_cnt = 0;
    bit            hold      = 1'b0;
    bit            all_idle;
    int            rr_last   = NE - 1;

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] word_at(input logic [AW-1:0] a);
        return ({16'h0, a} * 32'h9E3779B1) ^ {a, a};
    endfunction

    // driver: queue the reads and commands a job at base b must produce
    task automatic push_job(input logic [AW-1:0] b);
        for (int i = 0; i < N; i++) begin
            logic [AW-1:0] ra;
            logic [31:0] wx, wy, wr;
            ra = b + AW'(12 * i);
            exp_addr.push_back(ra);
            exp_addr.push_back(ra + AW'(4));
            exp_addr.push_back(ra + AW'(8));
            wx = word_at(ra);
            wy = word_at(ra + AW'(4));
            wr = word_at(ra + AW'(8));
            exp_cmd.push_back({wr[7:0], wy[8:0], wx[8:0]});
        end
    endtask

    task automatic cpu_write(input logic [RAW-1:0] off, input logic [31:0] d);
        @(negedge cpu_clk);
        cpu_wr_en = 1'b1;
        cpu_addr  = off;
        cpu_wdata = d;
        @(negedge cpu_clk);
        cpu_wr_en = 1'b0;
    endtask

    task automatic cpu_read(input logic [RAW-1:0] off, output logic [31:0] v);
        @(negedge cpu_clk);
        cpu_addr = off;
        #1;
        v = cpu_rdata;
    endtask

    task automatic wait_core(input int n);
        for (int i = 0; i < n; i++) @(negedge core_clk);
    endtask

    // monitor plus memory and engine models, all between core edges
    initial begin
        int cnt[NE];
        logic [NE-1:0] acc;
        logic [DW-1:0] mem_next;
        for (int k = 0; k < NE; k++) cnt[k] = 0;
        acc = '0;
        mem_next = '0;
        all_idle = 1'b1;
        forever begin
            @(negedge core_clk);
            for (int k = 0; k < NE; k++) begin
                if (acc[k]) cnt[k] = 30 + 11 * k;
                else if (cnt[k] > 0) cnt[k] = cnt[k] - 1;
                eng_busy[k]  = (cnt[k] != 0);
                eng_ready[k] = !hold && (cnt[k] == 0);
            end
            all_idle = (eng_busy == '0);
            mem_rdata = mem_next;
            acc = '0;
            #1;
            if (core_rst_n) begin
                if (mem_rd_en) begin
                    read_cnt++;
                    mem_next = word_at(mem_addr);
                    if (exp_addr.size() == 0) begin
                        check(1'b0, "R9 unexpected memory read", 32'(mem_addr), 32'h0);
                    end else begin
                        logic [AW-1:0] ea;
                        ea = exp_addr.pop_front();
                        check(mem_addr == ea, "R3 read address", 32'(mem_addr), 32'(ea));
                    end
                end
                if (eng_valid != '0) begin
                    int e;
                    int pick;
                    valid_cnt++;
                    acc = eng_valid;
                    check($onehot(eng_valid), "R5 one-hot valid", 32'(eng_valid), 32'h1);
                    check((eng_valid & ~eng_ready) == '0, "R5 valid to ready engine",
                          32'(eng_valid), 32'(eng_ready));
                    pick = -1;
                    for (int off = 1; off <= NE; off++) begin
                        e = (rr_last + off) % NE;
                        if (pick < 0 && eng_ready[e]) pick = e;
                    end
                    e = 0;
                    for (int k = 0; k < NE; k++) if (eng_valid[k]) e = k;
                    check(e == pick, "R6 round-robin choice", 32'(e), 32'(pick));
                    rr_last = e;
                    if (exp_cmd.size() == 0) begin
                        check(1'b0, "R9 unexpected dispatch", 32'(eng_cmd), 32'h0);
                    end else begin
                        logic [CW-1:0] ec;
                        ec = exp_cmd.pop_front();
                        check(eng_cmd == ec, "R4 packed command", 32'(eng_cmd), 32'(ec));
                    end
                end
            end
        end
    end

    task automatic wait_cmds_done(input string tag);
        int guard;
        guard = 0;
        while (exp_cmd.size() != 0 && guard < 20000) begin
            @(negedge core_clk);
            guard++;
        end
        check(exp_cmd.size() == 0, tag, 32'(exp_cmd.size()), 32'h0);
    endtask

    task automatic wait_not_busy(input string tag);
        logic [31:0] v;
        int guard;
        guard = 0;
        v = 32'h1;
        while (v != 0 && guard < 5000) begin
            cpu_read(RAW'(4), v);
            guard++;
        end
        check(v == 0, {tag, " status clears"}, v, 32'h0);
        check(all_idle, {tag, " R8 clear only after engines idle"}, 32'(all_idle), 32'h1);
    endtask

    initial begin
        logic [31:0] v;
        int rc, vc;
        #40;
        cpu_rst_n  = 1'b1;
        core_rst_n = 1'b1;

        // R1: reset state
        cpu_read(RAW'(4), v);
        check(v == 0, "R1 status after reset", v, 32'h0);
        #1;
        check(mem_rd_en == 1'b0, "R1 no read after reset", 32'(mem_rd_en), 32'h0);
        check(eng_valid == '0, "R1 no valid after reset", 32'(eng_valid), 32'h0);
        wait_core(20);
        check(read_cnt == 0, "R1 idle reads", 32'(read_cnt), 32'h0);

        // R11: other offsets
        cpu_write(RAW'(8), 32'h200);
        wait_core(40);
        check(read_cnt == 0, "R11 write to offset 8 starts nothing", 32'(read_cnt), 32'h0);
        cpu_read(RAW'(8), v);
        check(v == 0, "R11 offset 8 reads zero", v, 32'h0);
        cpu_read(RAW'(0), v);
        check(v == 0, "R11 offset 0 reads zero", v, 32'h0);
        cpu_read(RAW'(4), v);
        check(v == 0, "R11 status still idle", v, 32'h0);

        // job A with an ignored start in the middle
        push_job(AW'(16'h0100));
        cpu_write(RAW'(0), 32'h0000_0100);
        cpu_read(RAW'(4), v);
        check(v == 1, "R2 R10 status right after start", v, 32'h1);
        wait_core(60);
        cpu_write(RAW'(0), 32'h0000_0800);   // R9: must be ignored
        cpu_read(RAW'(4), v);
        check(v == 1, "R2 status mid job", v, 32'h1);
        wait_cmds_done("R4 job A all commands");
        cpu_read(RAW'(4), v);
        check(v == 1, "R8 status held during drain", v, 32'h1);
        wait_not_busy("R8 job A");
        rc = read_cnt;
        wait_core(80);
        check(read_cnt == rc, "R9 no job after ignored start", 32'(read_cnt), 32'(rc));
        check(exp_addr.size() == 0, "R3 job A all reads", 32'(exp_addr.size()), 32'h0);
        cpu_read(RAW'(4), v);
        check(v == 0, "R9 status stays idle", v, 32'h0);

        // job B with an engine stall
        push_job(AW'(16'h0600));
        cpu_write(RAW'(0), 32'h0000_0600);
        cpu_read(RAW'(4), v);
        check(v == 1, "R2 job B status", v, 32'h1);
        wait_core(30);
        @(negedge core_clk);
        hold = 1'b1;
        wait_core(12);
        rc = read_cnt;
        vc = valid_cnt;
        wait_core(40);
        check(read_cnt == rc, "R7 no reads while stalled", 32'(read_cnt), 32'(rc));
        check(valid_cnt == vc, "R7 no dispatch while stalled", 32'(valid_cnt), 32'(vc));
        hold = 1'b0;
        wait_cmds_done("R4 job B all commands");
        wait_not_busy("R8 job B");
        check(exp_addr.size() == 0, "R3 job B all reads", 32'(exp_addr.size()), 32'h0);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #750000;
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule